// File: doc/BRIEF.md
# Rearming Edge Pulse Detector

This block watches one bit that is already synchronous to its clock and raises a one-cycle pulse for each rising edge, each falling edge, and either kind of edge. Each detector is a small wait-driven loop rather than a compare against a registered copy of the input. It first waits until the watched level is low. It then waits until the level is high, and in that same cycle it emits. After that it sits out a fixed rearm gap before it starts waiting for low again.

The falling detector is the rising detector fed with the inverted input. The two detectors run side by side, and the any-edge output merges their pulses. Because a wait ends in the very cycle its condition is met, a pulse appears combinationally in the cycle the input changes, with no added register delay.

An enable input lets the detectors run. While enable is low the outputs stay low and both detectors fall back to their wait-for-low state. Synchronising an asynchronous signal and filtering glitches are left to the logic in front of the block.

Top module: `epd_top`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) puts both detectors in their wait-for-low state. In the first cycle after reset, rise_pulse, fall_pulse and any_pulse are 0, and no rise can occur before a low sample has been taken after reset.
- R2: When the rising detector has seen sig_in low and sig_in is then 1 with enable high, rise_pulse is 1 combinationally in that same cycle, and only for that one cycle.
- R3: If sig_in is already 1 when the block starts, no rise_pulse is produced until sig_in has been sampled 0 at least once.
- R4: The falling detector behaves like the rising one on the inverted input. After sig_in has been sampled 1, fall_pulse is 1 in the cycle sig_in is 0.
- R5: any_pulse equals rise_pulse OR fall_pulse in every cycle.
- R6: After a pulse, the detector that produced it ignores sig_in for GAP_CYCLES cycles (default 1) and then returns to wait-for-low. With the default, a level held for only the one cycle that follows a pulse is not seen, so the edge that ends that level is not reported.
- R7: While enable is 0, all outputs are 0 and both detectors return to wait-for-low. After enable rises again, a rise first needs a 0 sample and a fall first needs a 1 sample.
- R8: rise_pulse and fall_pulse are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Lets the detectors run; when low, outputs are 0 and the detectors rearm |
| sig_in | input | 1 | Monitored level, synchronous to clk |
| rise_pulse | output | 1 | One-cycle pulse on a detected rising edge |
| fall_pulse | output | 1 | One-cycle pulse on a detected falling edge |
| any_pulse | output | 1 | OR of rise_pulse and fall_pulse |

## Verification
The assertions check every cycle that:
- the merged output equals the OR of the two pulses, and the two pulses never coincide;
- every rise is preceded by an enabled low sample and every fall by an enabled high sample;
- no pulse appears while enable is low or in the cycle straight after reset;
- no detector pulses twice in a row.

Only the bench scenarios can show the cases that depend on the input history:
- an edge is missed because the level before it fell inside the rearm gap;
- a start with the input already high produces no rise;
- a reset or an enable drop partway through discards the progress a detector had made.

// File: rtl/epd_pkg.sv
package epd_pkg;

    // Phases of one wait-driven edge loop
    typedef enum logic [1:0] {
        PH_WAIT_LOW  = 2'd0,
        PH_WAIT_HIGH = 2'd1,
        PH_REARM     = 2'd2
    } epd_phase_e;

endpackage

// File: rtl/epd_wait_unit.sv
module epd_wait_unit
    import epd_pkg::*;
#(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic watch,
    output logic pulse
);

    localparam int CNT_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

    typedef struct packed {
        epd_phase_e       phase;
        logic [CNT_W-1:0] gap_cnt;
    } unit_state_t;

    unit_state_t state_d, state_q;
    logic        pulse_d;

    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        if (!enable) begin
            state_d.phase   = PH_WAIT_LOW;
            state_d.gap_cnt = '0;
        end else begin
            unique case (state_q.phase)
                PH_WAIT_LOW: begin
                    // low seen: the high wait fails at once, one tick later check again
                    if (!watch) begin
                        state_d.phase = PH_WAIT_HIGH;
                    end
                end
                PH_WAIT_HIGH: begin
                    if (watch) begin
                        pulse_d         = 1'b1;
                        state_d.phase   = PH_REARM;
                        state_d.gap_cnt = '0;
                    end
                end
                PH_REARM: begin
                    if (state_q.gap_cnt == GAP_LAST) begin
                        state_d.phase   = PH_WAIT_LOW;
                        state_d.gap_cnt = '0;
                    end else begin
                        state_d.gap_cnt = state_q.gap_cnt + 1'b1;
                    end
                end
                default: begin
                    state_d.phase   = PH_WAIT_LOW;
                    state_d.gap_cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.phase   <= PH_WAIT_LOW;
            state_q.gap_cnt <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pulse = pulse_d;

endmodule

// File: rtl/epd_top.sv
module epd_top #(
    parameter int GAP_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sig_in,
    output logic rise_pulse,
    output logic fall_pulse,
    output logic any_pulse
);

    localparam int N_DET = 2;  // index 0: rising, index 1: falling

    logic [N_DET-1:0] det_pulse;

    for (genvar g = 0; g < N_DET; g++) begin : g_det
        logic watch_lvl;
        if (g == 0) begin : g_pos
            assign watch_lvl = sig_in;
        end else begin : g_neg
            assign watch_lvl = ~sig_in;
        end
        epd_wait_unit #(
            .GAP_CYCLES(GAP_CYCLES)
        ) i_unit (
            .clk   (clk),
            .rst   (rst),
            .enable(enable),
            .watch (watch_lvl),
            .pulse (det_pulse[g])
        );
    end

    assign rise_pulse = det_pulse[0];
    assign fall_pulse = det_pulse[1];
    assign any_pulse  = |det_pulse;

endmodule

// File: rtl/epd_checks.sv
module epd_checks (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic sig_in,
    input logic rise_pulse,
    input logic fall_pulse,
    input logic any_pulse
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rise_pulse && !fall_pulse && !any_pulse);

    assert_rise_needs_low_R2: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |-> sig_in && $past(!sig_in) && $past(enable));

    assert_rise_single_R2: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

    assert_fall_needs_high_R4: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |-> !sig_in && $past(sig_in) && $past(enable));

    assert_fall_single_R6: assert property (@(posedge clk) disable iff (rst)
        fall_pulse |=> !fall_pulse);

    assert_any_merge_R5: assert property (@(posedge clk) disable iff (rst)
        any_pulse == (rise_pulse || fall_pulse));

    assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !any_pulse);

    assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $countones({rise_pulse, fall_pulse}) <= 1);

endmodule

bind epd_top epd_checks i_checks (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .sig_in    (sig_in),
    .rise_pulse(rise_pulse),
    .fall_pulse(fall_pulse),
    .any_pulse (any_pulse)
);

// File: tb/test_epd_top.sv
`timescale 1ns/1ps
module test_epd_top;

    logic clk = 1'b0;
    logic rst;
    logic enable;
    logic sig_in;
    logic rise_pulse, fall_pulse, any_pulse;

    int checks   = 0;
    int failures = 0;

    always #4 clk = ~clk;  // 125 MHz

    epd_top i_epd_top (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .sig_in    (sig_in),
        .rise_pulse(rise_pulse),
        .fall_pulse(fall_pulse),
        .any_pulse (any_pulse)
    );

    // {sig_in, expected rise, expected fall}, enable held high, walk starts from reset
    localparam int NV = 14;
    localparam logic [2:0] WALK [NV] = '{
        3'b000, 3'b000, 3'b110, 3'b100, 3'b001, 3'b110, 3'b000,
        3'b100, 3'b001, 3'b000, 3'b110, 3'b100, 3'b100, 3'b001
    };

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // drive away from the edge, then sample the combinational outputs before the next edge
    task automatic step(input logic en, input logic s, input logic er, input logic ef,
                        input string tag);
        @(negedge clk);
        enable = en;
        sig_in = s;
        #1;
        check(rise_pulse, er, {tag, " rise"});
        check(fall_pulse, ef, {tag, " fall"});
        check(any_pulse, er | ef, {tag, " any R5"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst    = 1'b1;
        enable = 1'b0;
        sig_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst    = 1'b1;
        enable = 1'b0;
        sig_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: quiet reset state
        step(1'b0, 1'b0, 1'b0, 1'b0, "R1 reset state");

        // Vector walk: R2 R4 R5 R6 R8
        do_reset();
        for (int i = 0; i < NV; i++) begin
            step(1'b1, WALK[i][2], WALK[i][1], WALK[i][0],
                 $sformatf("R2/R4/R6 walk %0d", i));
        end

        // R3: input already high at start
        do_reset();
        step(1'b1, 1'b1, 1'b0, 1'b0, "R3 high at start c0");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R3 high at start c1");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R3 high at start c2");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R4 fall after high");
        step(1'b1, 1'b0, 1'b0, 1'b0, "R6 gap");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R3 rise after low");

        // R7: enable drop discards progress
        do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0, "R7 arm low");
        step(1'b0, 1'b1, 1'b0, 1'b0, "R7 disabled edge");
        step(1'b1, 1'b1, 1'b0, 1'b0, "R7 re-enabled high");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R7 fall after rearm");
        step(1'b1, 1'b1, 1'b1, 1'b0, "R7 rise after rearm");

        // R1: reset partway through discards a seen low
        do_reset();
        step(1'b1, 1'b0, 1'b0, 1'b0, "R1 arm low");
        @(negedge clk);
        rst    = 1'b1;
        sig_in = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1 reset in flight");
        rst = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0, "R1 no rise after reset");
        step(1'b1, 1'b0, 1'b0, 1'b1, "R1 fall path live");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule